// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This controller-side block owns the SDRAM command pins from the moment reset is released until the memory is ready for traffic. It keeps clock enable high and sends no-operation commands for a stable-power interval given in microseconds and converted to clocks from the clock frequency. It then closes all banks with a precharge-all and sends a configurable number of auto-refresh commands. After that it writes the mode register with CAS latency, burst type, burst length and write-burst mode. If enabled, it then writes the extended mode register with a partial-array self-refresh size.

Each command is followed by no-ops for its spacing: the precharge period, the refresh cycle or the mode-register delay, all given in clocks. When the last wait ends, a ready flag rises and the block holds no-ops on the bus. A start pulse reruns the whole sequence at any time. While ready, a reload request writes the extended mode register alone, without repeating power-up. The system must keep all banks idle when it makes that request.

Top module: `sdram_init_seq`

## Requirements
- R1: From the release of `rst_n`, which passes through a two-stage synchronizer, the block drives CKE high and NOP for exactly PWR_CLK+2 clocks, where PWR_CLK = CLK_MHZ*POWERUP_US. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1 with BA=0 and address 0. The same NOP with CKE high and ready low is driven while reset is held.
- R2: The first command is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 set, all other address bits and BA zero.
- R3: NUM_REFRESH auto-refresh commands (cs_n, ras_n and cas_n low, we_n high, address and BA zero) follow. The first comes T_RP_CLK clocks after the precharge and each next one T_RFC_CLK clocks after the previous.
- R4: A mode-register write (all four strobes low, BA=00) comes T_RFC_CLK clocks after the last refresh.
- R5: The mode-register address carries the burst-length code on A2..A0 unchanged, burst type on A3 (1 = interleaved) and {0, cas latency} on A6..A4 with latency 1..3 given on a 2-bit input. Single-bit write mode is on A9. All other bits are zero.
- R6: With the extended write enabled, an extended mode-register write (all four strobes low, BA=10) comes T_MRD_CLK clocks after the mode write. Its A1..A0 carry the array code (00 full, 01 half, 10 quarter) and all other bits are zero. With it disabled, no extended write is made.
- R7: Ready rises exactly T_MRD_CLK clocks after the last mode-type command and stays low before that. While ready is high, only NOP is driven.
- R8: A reload request sampled while ready drops ready in the next cycle. That cycle carries an extended mode-register write with the current array code, followed by NOPs. Ready returns T_MRD_CLK clocks after that write, with no precharge or refresh.
- R9: A reload request while not ready is ignored: the sequence timing and commands are unchanged and no extra extended write is made.
- R10: A start pulse sampled at any point restarts the sequence. From the next cycle, ready is low and NOP is driven for PWR_CLK clocks before a new precharge. Start takes priority over a reload request.
- R11: Every non-NOP command is followed by at least one NOP cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Restart the whole power-up sequence |
| prog_ext | input | 1 | Reload the extended mode register when ready |
| cfg_cas_lat | input | 2 | CAS latency 1..3 |
| cfg_burst_interleave | input | 1 | 1 = interleaved burst order |
| cfg_burst_len | input | 3 | Burst-length code (000=1, 001=2, 010=4, 011=8, 111=full page) |
| cfg_single_write | input | 1 | 1 = single-location writes |
| cfg_ext_en | input | 1 | Include the extended mode write in the sequence |
| cfg_pasr | input | 2 | Self-refresh array size code |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_ready | output | 1 | Initialization complete |

## Verification
The bench sweeps every legal combination of latency, burst type, burst-length code, write mode and array code, with the extended write on and off. It compares the pin vector cycle by cycle against a timeline computed from the timing parameters. An off-by-one in any wait counter shifts a command by one cycle, and a missing or extra refresh moves the mode write; both fail on the exact cycle. Mis-packed mode fields show up in the address word. The bench also restarts in the middle of a refresh wait, holds reload requests during the sequence, which must be ignored, and issues start together with a reload, which must restart rather than write the extended register.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR, ST_PRE, ST_W_RP, ST_REF, ST_W_RFC,
    ST_MRS, ST_W_MRD, ST_EMRS, ST_W_EMRD, ST_DONE
  } init_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sd_cmd_t CMD_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  localparam logic [1:0] BA_BASE_MODE = 2'b00;
  localparam logic [1:0] BA_EXT_MODE  = 2'b10;

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_mode_encode.sv
module sdram_mode_encode #(
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        cas_lat,
  input  logic              burst_interleave,
  input  logic [2:0]        burst_len,
  input  logic              single_write,
  input  logic [1:0]        pasr_sel,
  output logic [ADDR_W-1:0] mode_word,
  output logic [ADDR_W-1:0] ext_word
);
  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = burst_len;
    mode_word[3]   = burst_interleave;
    mode_word[6:4] = {1'b0, cas_lat};
    mode_word[9]   = single_write;
    ext_word       = '0;
    ext_word[1:0]  = pasr_sel;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int POWERUP_US  = 200,
  parameter int T_RP_CLK    = 3,
  parameter int T_RFC_CLK   = 7,
  parameter int T_MRD_CLK   = 2,
  parameter int NUM_REFRESH = 2,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              prog_ext,
  input  logic [1:0]        cfg_cas_lat,
  input  logic              cfg_burst_interleave,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_single_write,
  input  logic              cfg_ext_en,
  input  logic [1:0]        cfg_pasr,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_ready
);
  localparam int PWR_CLK = CLK_MHZ * POWERUP_US;
  localparam int MAX_A   = (PWR_CLK > T_RFC_CLK) ? PWR_CLK : T_RFC_CLK;
  localparam int MAX_B   = (T_RP_CLK > T_MRD_CLK) ? T_RP_CLK : T_MRD_CLK;
  localparam int MAX_V   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAX_V + 1);
  localparam int RW      = $clog2(NUM_REFRESH + 1);

  localparam logic [CW-1:0] LD_PWR = CW'(PWR_CLK - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP_CLK - 2);
  localparam logic [CW-1:0] LD_RFC = CW'(T_RFC_CLK - 2);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD_CLK - 2);
  localparam logic [RW-1:0] LD_REF = RW'(NUM_REFRESH - 1);

  logic              rst_n_i;
  logic              tmr_load, tmr_done;
  logic [CW-1:0]     tmr_val;
  logic [ADDR_W-1:0] mode_word, ext_word;

  init_state_e       state_q, state_d;
  logic [RW-1:0]     ref_q, ref_d;
  logic              ref_en;

  sd_cmd_t           cmd_q, cmd_d;
  logic [1:0]        ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ready_q, ready_d;

  sdram_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sdram_init_timer #(.CW(CW), .RST_VAL(PWR_CLK - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sdram_mode_encode #(.ADDR_W(ADDR_W)) u_encode (
    .cas_lat          (cfg_cas_lat),
    .burst_interleave (cfg_burst_interleave),
    .burst_len        (cfg_burst_len),
    .single_write     (cfg_single_write),
    .pasr_sel         (cfg_pasr),
    .mode_word        (mode_word),
    .ext_word         (ext_word)
  );

  // Sequencing: next state, timer loads and refresh count
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_en   = 1'b0;
    ref_d    = ref_q;
    if (start) begin
      state_d  = ST_PWR;
      tmr_load = 1'b1;
      tmr_val  = LD_PWR;
    end else begin
      unique case (state_q)
        ST_PWR:   if (tmr_done) state_d = ST_PRE;
        ST_PRE: begin
          state_d  = ST_W_RP;
          tmr_load = 1'b1;
          tmr_val  = LD_RP;
          ref_en   = 1'b1;
          ref_d    = LD_REF;
        end
        ST_W_RP:  if (tmr_done) state_d = ST_REF;
        ST_REF: begin
          state_d  = ST_W_RFC;
          tmr_load = 1'b1;
          tmr_val  = LD_RFC;
        end
        ST_W_RFC: begin
          if (tmr_done) begin
            if (ref_q != '0) begin
              state_d = ST_REF;
              ref_en  = 1'b1;
              ref_d   = ref_q - 1'b1;
            end else begin
              state_d = ST_MRS;
            end
          end
        end
        ST_MRS: begin
          state_d  = ST_W_MRD;
          tmr_load = 1'b1;
          tmr_val  = LD_MRD;
        end
        ST_W_MRD: if (tmr_done) state_d = cfg_ext_en ? ST_EMRS : ST_DONE;
        ST_EMRS: begin
          state_d  = ST_W_EMRD;
          tmr_load = 1'b1;
          tmr_val  = LD_MRD;
        end
        ST_W_EMRD: if (tmr_done) state_d = ST_DONE;
        ST_DONE:   if (prog_ext) state_d = ST_EMRS;
        default:   state_d = ST_PWR;
      endcase
    end
  end

  // Pin values for the state being entered
  always_comb begin
    cmd_d   = CMD_NOP;
    ba_d    = BA_BASE_MODE;
    addr_d  = '0;
    ready_d = 1'b0;
    unique case (state_d)
      ST_PRE: begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
      end
      ST_REF:  cmd_d = CMD_REF;
      ST_MRS: begin
        cmd_d  = CMD_MODE;
        addr_d = mode_word;
      end
      ST_EMRS: begin
        cmd_d  = CMD_MODE;
        ba_d   = BA_EXT_MODE;
        addr_d = ext_word;
      end
      ST_DONE: ready_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_PWR;
      ref_q   <= '0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ref_en) ref_q <= ref_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      ready_q <= ready_d;
    end
  end

  assign sd_cke     = 1'b1;
  assign sd_cs_n    = cmd_q.cs_n;
  assign sd_ras_n   = cmd_q.ras_n;
  assign sd_cas_n   = cmd_q.cas_n;
  assign sd_we_n    = cmd_q.we_n;
  assign sd_ba      = ba_q;
  assign sd_addr    = addr_q;
  assign init_ready = ready_q;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W    = 12,
  parameter int T_MRD_CLK = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              prog_ext,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [1:0]        sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_ready
);
  logic is_nop, is_pre, is_mode;
  logic [7:0] gap_q;

  assign is_nop  = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
  assign is_pre  = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
  assign is_mode = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

  // Cycles since the last mode-type command, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap_q <= 8'hff;
    else if (is_mode)        gap_q <= 8'd1;
    else if (gap_q != 8'hff) gap_q <= gap_q + 8'd1;
  end

  p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sd_addr[10] && sd_ba == 2'b00));

  p_ext_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mode && sd_ba != 2'b00) |-> (sd_ba == 2'b10 && sd_addr[ADDR_W-1:2] == '0));

  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_ready |-> is_nop);

  p_ready_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ready) |-> (gap_q == 8'(T_MRD_CLK)));

  p_prog_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (init_ready && prog_ext && !start) |=> (!init_ready && is_mode && sd_ba == 2'b10));

  p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!init_ready && is_nop));

  p_cmd_then_nop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W    (ADDR_W),
  .T_MRD_CLK (T_MRD_CLK)
) u_init_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .prog_ext   (prog_ext),
  .sd_cs_n    (sd_cs_n),
  .sd_ras_n   (sd_ras_n),
  .sd_cas_n   (sd_cas_n),
  .sd_we_n    (sd_we_n),
  .sd_ba      (sd_ba),
  .sd_addr    (sd_addr),
  .init_ready (init_ready)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int CLK_MHZ = 1;
  localparam int PUP_US  = 12;
  localparam int P       = CLK_MHZ * PUP_US;
  localparam int TRP     = 3;
  localparam int TRFC    = 5;
  localparam int TMRD    = 2;
  localparam int NREF    = 3;
  localparam int AW      = 12;

  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_MODE = 4'b0000;

  logic clk, rst_n, start, prog_ext;
  logic [1:0] cas, pasr;
  logic bt, wsb, ext;
  logic [2:0] bl;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_ready;
  logic [1:0] sd_ba;
  logic [AW-1:0] sd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .POWERUP_US(PUP_US), .T_RP_CLK(TRP), .T_RFC_CLK(TRFC),
    .T_MRD_CLK(TMRD), .NUM_REFRESH(NREF), .ADDR_W(AW)
  ) i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_ext(prog_ext),
    .cfg_cas_lat(cas), .cfg_burst_interleave(bt), .cfg_burst_len(bl),
    .cfg_single_write(wsb), .cfg_ext_en(ext), .cfg_pasr(pasr),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .init_ready(init_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [19:0] pk(input logic [3:0] c, input logic [1:0] b,
                                     input logic [11:0] a, input logic r);
    return {1'b1, c, b, a, r};
  endfunction

  function automatic logic [19:0] act();
    return {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, init_ready};
  endfunction

  task automatic chk(input string tag, input logic [19:0] a, input logic [19:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, a, e, $time);
    end
  endtask

  // Walk one sequence from k=0; ends at the negedge where ready is expected.
  task automatic run_seq(input int first_nops, input int abort_at);
    int pre_k, mrs_k, emrs_k, rdy_k;
    logic [11:0] mw;
    pre_k  = first_nops;
    mrs_k  = pre_k + TRP + NREF * TRFC;
    emrs_k = mrs_k + TMRD;
    rdy_k  = (ext ? emrs_k : mrs_k) + TMRD;
    mw     = {2'b00, wsb, 2'b00, 1'b0, cas, bt, bl};
    for (int k = 0; k <= rdy_k; k++) begin
      logic [19:0] e;
      string tag;
      if (k == abort_at) return;
      e   = pk(C_NOP, 2'b00, 12'h000, 1'b0);
      tag = (k < pre_k) ? "R1 power-up no-op" : "R11 spacing no-op";
      if (k == pre_k) begin e = pk(C_PRE, 2'b00, 12'h400, 1'b0); tag = "R2 precharge-all"; end
      for (int i = 0; i < NREF; i++)
        if (k == pre_k + TRP + i * TRFC) begin e = pk(C_REF, 2'b00, 12'h000, 1'b0); tag = "R3 refresh"; end
      if (k == mrs_k) begin e = pk(C_MODE, 2'b00, mw, 1'b0); tag = "R4/R5 mode write"; end
      if (ext && k == emrs_k) begin e = pk(C_MODE, 2'b10, {10'b0, pasr}, 1'b0); tag = "R6 ext mode write"; end
      if (k == rdy_k) begin e = pk(C_NOP, 2'b00, 12'h000, 1'b1); tag = "R7 ready"; end
      chk(tag, act(), e);
      if (k != rdy_k) @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; prog_ext = 1'b0;
    cas = 2'd3; bt = 1'b0; bl = 3'b011; wsb = 1'b0; ext = 1'b1; pasr = 2'b01;
    repeat (3) @(negedge clk);
    chk("R1 reset state", act(), pk(C_NOP, 2'b00, 12'h000, 1'b0));
    rst_n = 1'b1;
    run_seq(P + 2, -1);

    // R8: extended reload while ready
    pasr = 2'b10; prog_ext = 1'b1;
    @(negedge clk);
    prog_ext = 1'b0;
    chk("R8 reload ext write", act(), pk(C_MODE, 2'b10, 12'h002, 1'b0));
    for (int j = 1; j < TMRD; j++) begin
      @(negedge clk);
      chk("R8 reload wait", act(), pk(C_NOP, 2'b00, 12'h000, 1'b0));
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R8 ready back", act(), pk(C_NOP, 2'b00, 12'h000, 1'b1));
    end

    // Sweep of all legal mode settings, with and without extended write
    for (int c = 1; c <= 3; c++)
      for (int b = 0; b < 2; b++)
        for (int li = 0; li < 5; li++)
          for (int w = 0; w < 2; w++)
            for (int e = 0; e < 4; e++) begin
              cas  = 2'(c);
              bt   = b[0];
              bl   = (li == 4) ? 3'b111 : 3'(li);
              wsb  = w[0];
              ext  = (e != 3);
              pasr = (e == 3) ? 2'b00 : 2'(e);
              pulse_start();
              run_seq(P, -1);
            end

    // R9: reload request held through the whole sequence is ignored
    ext = 1'b0; cas = 2'd2; bt = 1'b1; bl = 3'b010; wsb = 1'b1;
    prog_ext = 1'b1;
    pulse_start();
    run_seq(P, -1);
    prog_ext = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R9 no extra command", act(), pk(C_NOP, 2'b00, 12'h000, 1'b1));
    end

    // R10: restart in the middle of the refresh phase
    ext = 1'b1; pasr = 2'b01;
    pulse_start();
    run_seq(P, P + TRP + 2);
    pulse_start();
    chk("R10 restart mid-sequence", act(), pk(C_NOP, 2'b00, 12'h000, 1'b0));
    run_seq(P, -1);

    // R10: start wins over a simultaneous reload request
    start = 1'b1; prog_ext = 1'b1;
    @(negedge clk);
    start = 1'b0; prog_ext = 1'b0;
    chk("R10 start over reload", act(), pk(C_NOP, 2'b00, 12'h000, 1'b0));
    run_seq(P, -1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule